// File: doc/BRIEF.md
# Scan-Line Array Element Datapath

This block is the arithmetic and storage datapath of one element in a linear array where each element handles one image column. A 32-entry, 20-bit register file drives a read bus (bus A) from one port and takes its write data from a result bus (bus B) on the other, so every cycle can read one register and write another, or the same one. Bus A and a selectable second operand feed an ALU with a barrel rotate/shift unit. The ALU output is bus B. An iterative multiply unit forms a 40-bit unsigned product one bit per cycle.

Two edge registers connect the element to its row. The neighbour register is loaded from bus B or from the left or right neighbour's neighbour register. The video register passes pixel words along the row: each shift takes the word from one side and presents its old contents on the other side. The block takes a decoded control word every cycle. Sequencing that control word, and any reduction across the array, is handled elsewhere.

Top module: `scanpe_datapath`

## Requirements
- R1: After reset every register-file entry, the neighbour register, the video register and both product halves read as zero.
- R2: When `wr_en_i` is 1, bus B is written into entry `wr_addr_i` at the clock edge, and `rd_addr_i` shows it on bus A after that edge. When `wr_en_i` is 0, no entry changes.
- R3: If a read and a write target the same entry in one cycle, bus A carries the old contents in that cycle and the new contents in the next.
- R4: Operand Y is chosen by `opnd_sel_i`: 0 immediate, 1 neighbour register, 2 video register, 3 product high half, 4 product low half, 5 to 7 zero. Op codes: 0 bus A, 1 Y, 2 A AND Y, 3 A OR Y, 4 A XOR Y, 5 NOT A. Code 15 gives zero.
- R5: Op 6 gives A+Y and op 7 gives A−Y, both modulo 2^20.
- R6: The shift amount is Y[4:0]. Op 8 shifts A left, op 9 shifts it right with zero fill, and op 10 shifts it right copying the sign bit. An amount of 20 to 31 shifts every bit out: zero for ops 8 and 9, all sign bits for op 10.
- R7: Op 11 rotates A left and op 12 rotates it right by Y[4:0]. An amount of 20 to 31 rotates by amount−20.
- R8: Op 13 loads the multiplicand from bus A and the multiplier from Y, and clears the high half. Op 14 adds the multiplicand to the high half when the low bit of the low half is 1, then shifts {high, low} right by one. After one op 13 and twenty op 14, {high, low} equals the 40-bit unsigned product. Both ops put zero on bus B.
- R9: `nbr_op_i` 0 holds the neighbour register, 1 loads it from bus B, 2 loads it from `nbr_left_i`, and 3 loads it from `nbr_right_i`. `nbr_o` shows it.
- R10: `vid_op_i` 0 holds the video register, 1 loads it from `video_in_i`, 2 loads it from bus B, and 3 clears it. `video_o` shows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 4 | ALU operation code |
| opnd_sel_i | input | 3 | Source of operand Y |
| imm_i | input | 20 | Immediate operand |
| rd_addr_i | input | 5 | Register driven onto bus A |
| wr_addr_i | input | 5 | Register written from bus B |
| wr_en_i | input | 1 | Register write enable |
| nbr_op_i | input | 2 | Neighbour register action |
| vid_op_i | input | 2 | Video register action |
| nbr_left_i | input | 20 | Left neighbour's neighbour register |
| nbr_right_i | input | 20 | Right neighbour's neighbour register |
| video_in_i | input | 20 | Video word arriving from the upstream element |
| bus_a_o | output | 20 | Read bus A |
| bus_b_o | output | 20 | Result bus B |
| nbr_o | output | 20 | Neighbour register |
| video_o | output | 20 | Video register, toward the downstream element |

## Verification
The product registers are the hardest state to reach from the ports. They change only over a 21-cycle op sequence, and they can be read only by routing them through operand Y onto bus B. The stimulus runs a full init-plus-twenty-step sequence for each operand pair, including all-ones times all-ones and a multiplier whose top bit is set, and then reads each half separately. Shift and rotate amounts are swept over all 32 codes. Junk is placed in the upper bits of Y so the bench can check that only Y[4:0] sets the amount.

// File: rtl/scanpe_pkg.sv
`timescale 1ns/1ps
package scanpe_pkg;

   typedef enum logic [3:0] {
      OP_PASS_A   = 4'd0,
      OP_PASS_Y   = 4'd1,
      OP_AND      = 4'd2,
      OP_OR       = 4'd3,
      OP_XOR      = 4'd4,
      OP_NOT_A    = 4'd5,
      OP_ADD      = 4'd6,
      OP_SUB      = 4'd7,
      OP_SHL      = 4'd8,
      OP_SHR      = 4'd9,
      OP_SRA      = 4'd10,
      OP_ROL      = 4'd11,
      OP_ROR      = 4'd12,
      OP_MUL_INIT = 4'd13,
      OP_MUL_STEP = 4'd14,
      OP_RSVD     = 4'd15
   } op_e;

   typedef enum logic [2:0] {
      SEL_IMM = 3'd0,
      SEL_NBR = 3'd1,
      SEL_VID = 3'd2,
      SEL_PHI = 3'd3,
      SEL_PLO = 3'd4
   } sel_e;

   typedef enum logic [1:0] {
      NB_HOLD  = 2'd0,
      NB_LOAD  = 2'd1,
      NB_LEFT  = 2'd2,
      NB_RIGHT = 2'd3
   } nb_e;

   typedef enum logic [1:0] {
      VD_HOLD  = 2'd0,
      VD_SHIFT = 2'd1,
      VD_LOAD  = 2'd2,
      VD_CLEAR = 2'd3
   } vd_e;

endpackage

// File: rtl/scanpe_regfile.sv
`timescale 1ns/1ps
module scanpe_regfile #(
   parameter int W     = 20,
   parameter int DEPTH = 32,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] raddr_i,
   output logic [W-1:0]  rdata_o,
   input  logic          we_i,
   input  logic [AW-1:0] waddr_i,
   input  logic [W-1:0]  wdata_i
);

   logic [W-1:0] mem_q [DEPTH];

   // The read port sees flop outputs, so a write in the same cycle shows up one edge later.
   assign rdata_o = mem_q[raddr_i];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      end else if (we_i) begin
         mem_q[waddr_i] <= wdata_i;
      end
   end

   p_wr_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
      we_i |=> (mem_q[$past(waddr_i)] == $past(wdata_i)));

   p_no_wr_keeps_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !we_i |=> (mem_q[$past(raddr_i)] == $past(rdata_o)));

endmodule

// File: rtl/scanpe_rsu.sv
`timescale 1ns/1ps
module scanpe_rsu
   import scanpe_pkg::*;
#(
   parameter int W   = 20,
   localparam int SW = $clog2(W)
) (
   input  op_e           op_i,
   input  logic [W-1:0]  x_i,
   input  logic [SW-1:0] amt_i,
   output logic [W-1:0]  y_o
);

   localparam logic [SW:0] WIDTH_V = (SW+1)'(W);

   logic [SW:0]   amt_x, red, inv;
   logic [SW-1:0] rot_l, rot_r, rot_amt;
   logic [W-1:0]  shl_v, shr_v, sra_v, rot_v;
   logic signed [W-1:0] xs;

   // Fold amounts of W and above back into range for rotation.
   assign amt_x   = {1'b0, amt_i};
   assign red     = (amt_x >= WIDTH_V) ? (amt_x - WIDTH_V) : amt_x;
   assign inv     = WIDTH_V - red;
   assign rot_l   = red[SW-1:0];
   assign rot_r   = (red == '0) ? '0 : inv[SW-1:0];
   assign rot_amt = (op_i == OP_ROR) ? rot_r : rot_l;

   // Log-stage rotate-left network.
   for (genvar k = 0; k < SW; k++) begin : g_rot
      localparam int D = 1 << k;
      logic [W-1:0] src, q;
      if (k == 0) begin : g_first
         assign src = x_i;
      end else begin : g_next
         assign src = g_rot[k-1].q;
      end
      assign q = rot_amt[k] ? {src[W-1-D:0], src[W-1 -: D]} : src;
   end
   assign rot_v = g_rot[SW-1].q;

   assign xs    = $signed(x_i);
   assign shl_v = x_i << amt_i;
   assign shr_v = x_i >> amt_i;
   assign sra_v = xs >>> amt_i;

   always_comb begin
      case (op_i)
         OP_SHL:          y_o = shl_v;
         OP_SHR:          y_o = shr_v;
         OP_SRA:          y_o = sra_v;
         OP_ROL, OP_ROR:  y_o = rot_v;
         default:         y_o = '0;
      endcase
   end

endmodule

// File: rtl/scanpe_alu.sv
`timescale 1ns/1ps
module scanpe_alu
   import scanpe_pkg::*;
#(
   parameter int W   = 20,
   localparam int SW = $clog2(W)
) (
   input  op_e          op_i,
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] y_i,
   output logic [W-1:0] res_o
);

   logic [W-1:0] rsu_v;

   scanpe_rsu #(.W(W)) u_rsu (
      .op_i  (op_i),
      .x_i   (a_i),
      .amt_i (y_i[SW-1:0]),
      .y_o   (rsu_v)
   );

   always_comb begin
      case (op_i)
         OP_PASS_A: res_o = a_i;
         OP_PASS_Y: res_o = y_i;
         OP_AND:    res_o = a_i & y_i;
         OP_OR:     res_o = a_i | y_i;
         OP_XOR:    res_o = a_i ^ y_i;
         OP_NOT_A:  res_o = ~a_i;
         OP_ADD:    res_o = a_i + y_i;
         OP_SUB:    res_o = a_i - y_i;
         OP_SHL, OP_SHR, OP_SRA, OP_ROL, OP_ROR: res_o = rsu_v;
         default:   res_o = '0;
      endcase
   end

endmodule

// File: rtl/scanpe_mul.sv
`timescale 1ns/1ps
module scanpe_mul #(
   parameter int W  = 20,
   parameter bit EN = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         init_i,
   input  logic         step_i,
   input  logic [W-1:0] mcand_i,
   input  logic [W-1:0] mplier_i,
   output logic [W-1:0] hi_o,
   output logic [W-1:0] lo_o
);

   if (EN) begin : g_mul
      logic [W-1:0] cand_q, hi_q, lo_q;
      logic [W:0]   sum;

      assign sum = lo_q[0] ? ({1'b0, hi_q} + {1'b0, cand_q}) : {1'b0, hi_q};

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cand_q <= '0;
            hi_q   <= '0;
            lo_q   <= '0;
         end else if (init_i) begin
            cand_q <= mcand_i;
            hi_q   <= '0;
            lo_q   <= mplier_i;
         end else if (step_i) begin
            hi_q <= sum[W:1];
            lo_q <= {sum[0], lo_q[W-1:1]};
         end
      end

      assign hi_o = hi_q;
      assign lo_o = lo_q;

      p_mul_lo_shift_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (step_i && !init_i) |=> (lo_q[W-2:0] == $past(lo_q[W-1:1])));

      p_mul_skip_add_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (step_i && !init_i && !lo_q[0]) |=> (hi_q == ($past(hi_q) >> 1)));

      p_mul_init_r8: assert property (@(posedge clk) disable iff (!rst_n)
         init_i |=> (hi_q == '0));
   end else begin : g_nomul
      assign hi_o = '0;
      assign lo_o = '0;
   end

endmodule

// File: rtl/scanpe_edge.sv
`timescale 1ns/1ps
module scanpe_edge
   import scanpe_pkg::*;
#(
   parameter int W = 20
) (
   input  logic         clk,
   input  logic         rst_n,
   input  nb_e          nb_op_i,
   input  vd_e          vd_op_i,
   input  logic [W-1:0] busb_i,
   input  logic [W-1:0] left_i,
   input  logic [W-1:0] right_i,
   input  logic [W-1:0] vin_i,
   output logic [W-1:0] nbr_o,
   output logic [W-1:0] vid_o
);

   logic [W-1:0] nbr_q, vid_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         nbr_q <= '0;
      end else begin
         case (nb_op_i)
            NB_LOAD:  nbr_q <= busb_i;
            NB_LEFT:  nbr_q <= left_i;
            NB_RIGHT: nbr_q <= right_i;
            default:  nbr_q <= nbr_q;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vid_q <= '0;
      end else begin
         case (vd_op_i)
            VD_SHIFT: vid_q <= vin_i;
            VD_LOAD:  vid_q <= busb_i;
            VD_CLEAR: vid_q <= '0;
            default:  vid_q <= vid_q;
         endcase
      end
   end

   assign nbr_o = nbr_q;
   assign vid_o = vid_q;

   p_nbr_left_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (nb_op_i == NB_LEFT) |=> (nbr_o == $past(left_i)));

   p_nbr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (nb_op_i == NB_HOLD) |=> $stable(nbr_o));

   p_vid_shift_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (vd_op_i == VD_SHIFT) |=> (vid_o == $past(vin_i)));

   p_vid_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (vd_op_i == VD_CLEAR) |=> (vid_o == '0));

endmodule

// File: rtl/scanpe_datapath.sv
`timescale 1ns/1ps
module scanpe_datapath
   import scanpe_pkg::*;
#(
   parameter int DATA_W = 20,
   parameter int NREGS  = 32,
   parameter bit MUL_EN = 1'b1,
   localparam int AW    = $clog2(NREGS),
   localparam int SW    = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [3:0]        op_i,
   input  logic [2:0]        opnd_sel_i,
   input  logic [DATA_W-1:0] imm_i,
   input  logic [AW-1:0]     rd_addr_i,
   input  logic [AW-1:0]     wr_addr_i,
   input  logic              wr_en_i,
   input  logic [1:0]        nbr_op_i,
   input  logic [1:0]        vid_op_i,
   input  logic [DATA_W-1:0] nbr_left_i,
   input  logic [DATA_W-1:0] nbr_right_i,
   input  logic [DATA_W-1:0] video_in_i,
   output logic [DATA_W-1:0] bus_a_o,
   output logic [DATA_W-1:0] bus_b_o,
   output logic [DATA_W-1:0] nbr_o,
   output logic [DATA_W-1:0] video_o
);

   // Elaboration-time parameter checks.
   if (DATA_W < 4) begin : g_bad_width
      $error("scanpe_datapath: DATA_W must be at least 4");
   end
   if ((1 << AW) != NREGS) begin : g_bad_depth
      $error("scanpe_datapath: NREGS must be a power of two");
   end

   op_e                op;
   logic [DATA_W-1:0]  bus_a, bus_b, y_opnd, prod_hi, prod_lo, nbr_v, vid_v;

   assign op = op_e'(op_i);

   scanpe_regfile #(.W(DATA_W), .DEPTH(NREGS)) u_rf (
      .clk     (clk),
      .rst_n   (rst_n),
      .raddr_i (rd_addr_i),
      .rdata_o (bus_a),
      .we_i    (wr_en_i),
      .waddr_i (wr_addr_i),
      .wdata_i (bus_b)
   );

   always_comb begin
      case (sel_e'(opnd_sel_i))
         SEL_IMM: y_opnd = imm_i;
         SEL_NBR: y_opnd = nbr_v;
         SEL_VID: y_opnd = vid_v;
         SEL_PHI: y_opnd = prod_hi;
         SEL_PLO: y_opnd = prod_lo;
         default: y_opnd = '0;
      endcase
   end

   scanpe_alu #(.W(DATA_W)) u_alu (
      .op_i  (op),
      .a_i   (bus_a),
      .y_i   (y_opnd),
      .res_o (bus_b)
   );

   scanpe_mul #(.W(DATA_W), .EN(MUL_EN)) u_mul (
      .clk      (clk),
      .rst_n    (rst_n),
      .init_i   (op == OP_MUL_INIT),
      .step_i   (op == OP_MUL_STEP),
      .mcand_i  (bus_a),
      .mplier_i (y_opnd),
      .hi_o     (prod_hi),
      .lo_o     (prod_lo)
   );

   scanpe_edge #(.W(DATA_W)) u_edge (
      .clk     (clk),
      .rst_n   (rst_n),
      .nb_op_i (nb_e'(nbr_op_i)),
      .vd_op_i (vd_e'(vid_op_i)),
      .busb_i  (bus_b),
      .left_i  (nbr_left_i),
      .right_i (nbr_right_i),
      .vin_i   (video_in_i),
      .nbr_o   (nbr_v),
      .vid_o   (vid_v)
   );

   assign bus_a_o = bus_a;
   assign bus_b_o = bus_b;
   assign nbr_o   = nbr_v;
   assign video_o = vid_v;

   p_sra_sign_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_SRA) |-> (bus_b_o[DATA_W-1] == bus_a_o[DATA_W-1]));

   p_rol_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_ROL && y_opnd[SW-1:0] == '0) |-> (bus_b_o == bus_a_o));

   p_sub_inverse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_SUB) |-> (DATA_W'(bus_b_o + y_opnd) == bus_a_o));

   p_mul_bus_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_MUL_INIT || op == OP_MUL_STEP) |-> (bus_b_o == '0));

endmodule

// File: tb/test_scanpe_datapath.sv
`timescale 1ns/1ps
module test_scanpe_datapath;

   localparam int W = 20;
   localparam longint unsigned M = (64'd1 << W) - 1;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [3:0]   op;
   logic [2:0]   sel;
   logic [W-1:0] imm, nl, nr, vin;
   logic [4:0]   ra, wa;
   logic         we;
   logic [1:0]   nb, vd;
   logic [W-1:0] bus_a, bus_b, nbr, vid;

   int n_chk  = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   scanpe_datapath i_scanpe_datapath (
      .clk(clk), .rst_n(rst_n), .op_i(op), .opnd_sel_i(sel), .imm_i(imm),
      .rd_addr_i(ra), .wr_addr_i(wa), .wr_en_i(we), .nbr_op_i(nb), .vid_op_i(vd),
      .nbr_left_i(nl), .nbr_right_i(nr), .video_in_i(vin),
      .bus_a_o(bus_a), .bus_b_o(bus_b), .nbr_o(nbr), .video_o(vid)
   );

   task automatic chk(input string req, input longint unsigned act, input longint unsigned exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic idle();
      op = 4'd0; sel = 3'd0; imm = '0; we = 1'b0; nb = 2'd0; vd = 2'd0;
      ra = '0; wa = '0; nl = '0; nr = '0; vin = '0;
   endtask

   // All tasks are entered just after a falling edge and return just after the next one.
   task automatic load(input int addr, input longint unsigned val);
      op = 4'd1; sel = 3'd0; imm = W'(val); wa = 5'(addr); we = 1'b1;
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic eval(input int addr, input int code, input longint unsigned y,
                       output longint unsigned res);
      ra = 5'(addr); op = 4'(code); sel = 3'd0; imm = W'(y); we = 1'b0;
      #2 res = longint'(bus_b);
      @(negedge clk);
   endtask

   function automatic longint unsigned model(input int code, input longint unsigned x,
                                             input longint unsigned y);
      longint unsigned amt, r;
      longint sx;
      amt = y & 31;
      case (code)
         0: return x;
         1: return y;
         2: return x & y;
         3: return x | y;
         4: return x ^ y;
         5: return (~x) & M;
         6: return (x + y) & M;
         7: return (x + (M + 1) - y) & M;
         8: return (amt >= W) ? 0 : ((x << amt) & M);
         9: return (amt >= W) ? 0 : (x >> amt);
         10: begin
            sx = (x >= 64'h80000) ? longint'(x) - longint'(M + 1) : longint'(x);
            if (amt > W - 1) amt = W - 1;
            return longint'(sx >>> amt) & M;
         end
         11: begin
            r = (amt >= W) ? amt - W : amt;
            return ((x << r) | (x >> (W - r))) & M;
         end
         12: begin
            r = (amt >= W) ? amt - W : amt;
            return ((x >> r) | (x << (W - r))) & M;
         end
         default: return 0;
      endcase
   endfunction

   function automatic string tag(input int code);
      if (code <= 5 || code == 15) return "R4";
      if (code <= 7) return "R5";
      if (code <= 10) return "R6";
      if (code <= 12) return "R7";
      return "R8";
   endfunction

   function automatic longint unsigned pat(input int i);
      return ((longint'(i) * 64'd40503 + 64'd777) ^ (longint'(i) << 13)) & M;
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      longint unsigned res, x, y, prod;
      longint unsigned corners [7];
      longint unsigned ma [7];
      longint unsigned mb [7];
      int codes [9];
      corners = '{64'h0, 64'h1, 64'hFFFFF, 64'h80000, 64'h7FFFF, 64'h55555, 64'hAAAAA};
      ma = '{64'h0, 64'h1, 64'hFFFFF, 64'h12345, 64'h80000, 64'hFFFFF, 64'hABCDE};
      mb = '{64'h0, 64'h1, 64'hFFFFF, 64'h06789, 64'h00003, 64'h80001, 64'h13579};
      codes = '{0, 1, 2, 3, 4, 5, 6, 7, 15};
      idle();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      for (int i = 0; i < 32; i++) begin
         ra = 5'(i);
         #2 chk("R1 register after reset", longint'(bus_a), 0);
         @(negedge clk);
      end
      chk("R1 neighbour after reset", longint'(nbr), 0);
      chk("R1 video after reset", longint'(vid), 0);
      op = 4'd1; sel = 3'd3;
      #2 chk("R1 product high after reset", longint'(bus_b), 0);
      sel = 3'd4;
      #2 chk("R1 product low after reset", longint'(bus_b), 0);
      @(negedge clk);
      idle();

      // R2: write every entry, read all back
      for (int i = 0; i < 32; i++) load(i, pat(i));
      for (int i = 0; i < 32; i++) begin
         ra = 5'(i);
         #2 chk("R2 readback", longint'(bus_a), pat(i));
         @(negedge clk);
      end
      // R2: disabled write leaves the entry alone
      op = 4'd1; sel = 3'd0; imm = W'(~pat(3)); wa = 5'd3; we = 1'b0;
      @(negedge clk);
      ra = 5'd3;
      #2 chk("R2 no write when disabled", longint'(bus_a), pat(3));
      @(negedge clk);

      // R3: same-address read and write
      ra = 5'd9; wa = 5'd9; we = 1'b1; op = 4'd1; sel = 3'd0; imm = 20'h12345;
      #2 chk("R3 old value during write", longint'(bus_a), pat(9));
      @(negedge clk);
      we = 1'b0;
      #2 chk("R3 new value next cycle", longint'(bus_a), 64'h12345);
      @(negedge clk);
      idle();

      // R4/R5: logic and arithmetic over corner pairs
      foreach (corners[xi]) begin
         load(20, corners[xi]);
         foreach (corners[yi]) begin
            foreach (codes[ci]) begin
               eval(20, codes[ci], corners[yi], res);
               chk($sformatf("%s op %0d x=%h y=%h", tag(codes[ci]), codes[ci], corners[xi], corners[yi]),
                   res, model(codes[ci], corners[xi], corners[yi]));
            end
         end
      end

      // R6/R7: every shift and rotate amount, junk in the upper Y bits
      foreach (corners[xi]) begin
         x = corners[xi] ^ 64'h0F0F1;
         load(21, x);
         for (int amt = 0; amt < 32; amt++) begin
            y = (((x * 7) << 5) | longint'(amt)) & M;
            for (int code = 8; code <= 12; code++) begin
               eval(21, code, y, res);
               chk($sformatf("%s op %0d x=%h amt=%0d", tag(code), code, x, amt),
                   res, model(code, x, y));
            end
         end
      end

      // R8: full multiply sequences
      foreach (ma[pi]) begin
         load(7, ma[pi]);
         eval(7, 13, mb[pi], res);
         chk("R8 init puts zero on bus B", res, 0);
         for (int s = 0; s < 20; s++) begin
            eval(7, 14, 64'h5A5A5, res);
            if (s == 10) chk("R8 step puts zero on bus B", res, 0);
         end
         prod = ma[pi] * mb[pi];
         op = 4'd1; sel = 3'd3;
         #2 chk($sformatf("R8 product high %h*%h", ma[pi], mb[pi]), longint'(bus_b), prod >> W);
         sel = 3'd4;
         #2 chk($sformatf("R8 product low %h*%h", ma[pi], mb[pi]), longint'(bus_b), prod & M);
         @(negedge clk);
         idle();
      end

      // R9: neighbour register
      nl = 20'hABCDE; nr = 20'h13579; nb = 2'd2;
      @(negedge clk);
      chk("R9 load from left", longint'(nbr), 64'hABCDE);
      nb = 2'd3;
      @(negedge clk);
      chk("R9 load from right", longint'(nbr), 64'h13579);
      nb = 2'd0; nl = 20'h0; nr = 20'h0;
      @(negedge clk);
      chk("R9 hold", longint'(nbr), 64'h13579);
      nb = 2'd1; op = 4'd1; sel = 3'd0; imm = 20'h2468A;
      @(negedge clk);
      chk("R9 load from bus B", longint'(nbr), 64'h2468A);
      nb = 2'd0; sel = 3'd1;
      #2 chk("R9 readback through operand select", longint'(bus_b), 64'h2468A);
      @(negedge clk);
      idle();

      // R10: video register
      for (int k = 0; k < 6; k++) begin
         vd = 2'd1; vin = W'(k * 64'h11111 + 3);
         @(negedge clk);
         chk($sformatf("R10 shift step %0d", k), longint'(vid), (k * 64'h11111 + 3) & M);
      end
      vd = 2'd0; vin = 20'hFFFFF;
      @(negedge clk);
      chk("R10 hold", longint'(vid), (5 * 64'h11111 + 3) & M);
      vd = 2'd2; op = 4'd1; sel = 3'd0; imm = 20'h3C3C3;
      @(negedge clk);
      chk("R10 load from bus B", longint'(vid), 64'h3C3C3);
      vd = 2'd0; sel = 3'd2;
      #2 chk("R10 readback through operand select", longint'(bus_b), 64'h3C3C3);
      @(negedge clk);
      vd = 2'd3;
      @(negedge clk);
      chk("R10 clear", longint'(vid), 0);
      idle();

      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

endmodule